// File: doc/BRIEF.md
# SDLC Transmit Framer

This block turns a stream of bytes into a bit-oriented synchronous frame on a single serial line. It advances one bit per cycle in which the bit-enable input is high. When it is enabled and has no data, it fills the line with flag octets. When a byte is waiting in its one-byte holding buffer at the end of a flag, a frame begins. The byte goes out least significant bit first, and each following byte is taken from the buffer as the previous one finishes. When the host asks for the end of the message, or the buffer runs dry, the block appends a 16-bit frame check sequence and a closing flag, then returns to sending flags.

A zero is stuffed into the line after every run of five ones in the payload and the check sequence, so the receiver can never mistake data for a flag. A break request pulls the line low at once, whatever the enable state. An optional clear-to-send gate stops new frames from starting. When the gate closes during flag fill, the line returns to marking after the flag in progress.

Top module: `sdlc_tx_framer`

## Requirements
- R1: Out of reset `txd` is 1, `bufEmpty` is 1, `dataReady` is 1 and `underrun` is 0. After a bit tick taken with `txEnable` low, `txd` is 1 (marking).
- R2: While `sendBreak` is 1, `txd` is 0 in the same cycle, whether or not the transmitter is enabled. Releasing it restores the line value the framer is producing.
- R3: The transmitter may be enabled with an empty buffer and the CTS gate open. The tick on which enable is first seen sends a 1. After that, flags of value 0x7E go out back to back, each least significant bit first (0,1,1,1,1,1,1,0), with no gaps.
- R4: `dataReady` equals `bufEmpty`. A byte is accepted on a clock edge where `dataValid` and `dataReady` are both 1, and `bufEmpty` is 0 from the next cycle. The buffer empties on the bit tick that moves the byte into the shifter.
- R5: A frame starts only at the end of a complete flag. Data bytes follow the opening flag in the order they were accepted, each least significant bit first.
- R6: After five consecutive ones in the payload or check sequence, a 0 is inserted. Runs of ones are counted from the start of the frame, and no zero is inserted inside flags.
- R7: The check sequence is the ones-complement of a CRC over x^16+x^12+x^5+1, preset to all ones at frame start. It is sent low-order bit first after the byte during which `eomReq` was pulsed, and a full flag follows it.
- R8: If a byte ends with an empty buffer and no end-of-message request, `underrun` goes to 1 and the frame is closed with check sequence and flag. `underrun` stays 1 until the next frame starts.
- R9: With `ctsGateEn` 1 and `ctsActive` 0, no flag or frame starts. A flag already in progress is completed, then the line marks. A waiting byte stays buffered until `ctsActive` returns to 1.
- R10: An `eomReq` pulse while no data byte is being shifted out has no effect on the next frame.
- R11: `txd` changes only after clock edges on which `bitEn` was 1 (break aside), and frames stay correct when ticks are sparse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-rate tick; one line bit per high cycle |
| txEnable | input | 1 | Transmitter enable |
| sendBreak | input | 1 | Force the line low |
| ctsGateEn | input | 1 | Use `ctsActive` to gate frame starts |
| ctsActive | input | 1 | Clear-to-send, active high |
| dataValid | input | 1 | Host offers a byte on `dataIn` |
| dataIn | input | 8 | Byte offered to the buffer |
| dataReady | output | 1 | Buffer can accept a byte |
| eomReq | input | 1 | Pulse: close the frame after the byte now being sent |
| txd | output | 1 | Serial line output |
| bufEmpty | output | 1 | Holding buffer is empty |
| underrun | output | 1 | Frame was closed because data ran out |

## Verification
The hardest condition to reach from the ports is a run of five ones that ends exactly on the last check-sequence bit. In that case a stuffed zero must come before the closing flag, and stuffing state carries across the byte-to-check-sequence boundary. The bench sends every one of the 256 single-byte payloads, which reliably produces both endings. For each frame it predicts the check sequence and the count of stuffed zeros arithmetically, and compares them with what a bench-side destuffing receiver decodes from `txd`. The CTS drop is timed to land inside a flag, so the test shows that exactly one more complete flag is seen before the line marks.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  localparam logic [7:0] FLAG_OCTET = 8'h7E;

  typedef enum logic [2:0] {
    SEL_MARK,
    SEL_FLAG,
    SEL_ZERO,
    SEL_DATA,
    SEL_FCS
  } lineSel_t;

  typedef struct packed {
    logic     tick;
    lineSel_t sel;
    logic     flagBit;
    logic     loadByte;
    logic     presetFcs;
  } txStrobe_t;

endpackage

// File: rtl/sdlc_tx_dp.sv
module sdlc_tx_dp
  import sdlc_tx_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          FCS_W     = 16,
  parameter logic [15:0] FCS_POLY  = 16'h8408,
  parameter int          RUN_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] dataIn,
  output logic              dataReady,
  output logic              bufFull,
  output logic              stuffDue,
  output logic              txdReg
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);

  logic [BYTE_W-1:0] bufByte;
  logic [BYTE_W-1:0] shiftQ;
  logic [FCS_W-1:0]  fcsQ;
  logic [FCS_W-1:0]  fcsStep;
  logic [RUN_W-1:0]  runQ;
  logic              bufFullQ;
  logic              txdQ;
  logic              fcsOut;

  // Serial CRC step, bit taken LSB first from the shifter
  always_comb begin
    fcsStep = fcsQ >> 1;
    if (fcsQ[0] ^ shiftQ[0]) fcsStep = fcsStep ^ FCS_POLY[FCS_W-1:0];
  end

  assign fcsOut    = ~fcsQ[0];
  assign bufFull   = bufFullQ;
  assign dataReady = ~bufFullQ;
  assign stuffDue  = (runQ == RUN_W'(RUN_LIMIT));
  assign txdReg    = txdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufByte  <= '0;
      bufFullQ <= 1'b0;
      shiftQ   <= '0;
      fcsQ     <= '1;
      runQ     <= '0;
      txdQ     <= 1'b1;
    end else begin
      if (dataValid && !bufFullQ) begin
        bufByte  <= dataIn;
        bufFullQ <= 1'b1;
      end else if (stb.tick && stb.loadByte) begin
        bufFullQ <= 1'b0;
      end

      if (stb.tick) begin
        unique case (stb.sel)
          SEL_FLAG: begin
            txdQ <= stb.flagBit;
            runQ <= '0;
          end
          SEL_ZERO: begin
            txdQ <= 1'b0;
            runQ <= '0;
          end
          SEL_DATA: begin
            txdQ <= shiftQ[0];
            runQ <= shiftQ[0] ? runQ + RUN_W'(1) : '0;
            fcsQ <= fcsStep;
          end
          SEL_FCS: begin
            txdQ <= fcsOut;
            runQ <= fcsOut ? runQ + RUN_W'(1) : '0;
            fcsQ <= {1'b1, fcsQ[FCS_W-1:1]};
          end
          default: begin
            txdQ <= 1'b1;
            runQ <= '0;
          end
        endcase

        if (stb.loadByte)            shiftQ <= bufByte;
        else if (stb.sel == SEL_DATA) shiftQ <= shiftQ >> 1;

        if (stb.presetFcs) fcsQ <= '1;
      end
    end
  end

endmodule

// File: rtl/sdlc_tx_ctrl.sv
module sdlc_tx_ctrl
  import sdlc_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FCS_W  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      txEnable,
  input  logic      ctsGateEn,
  input  logic      ctsActive,
  input  logic      eomReq,
  input  logic      bufFull,
  input  logic      stuffDue,
  output txStrobe_t stb,
  output logic      underrun
);

  localparam int MAX_LEN = (FCS_W > BYTE_W) ? FCS_W : BYTE_W;
  localparam int CNT_W   = $clog2(MAX_LEN);

  typedef enum logic [1:0] {ST_IDLE, ST_FLAG, ST_DATA, ST_FCS} txState_t;

  txState_t   stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic       eomQ, eomD;
  logic       underrunQ, underrunD;
  logic       gated;

  assign gated    = ctsGateEn && !ctsActive;
  assign underrun = underrunQ;

  always_comb begin
    stateD        = stateQ;
    cntD          = cntQ;
    eomD          = eomQ | (eomReq && stateQ == ST_DATA);
    underrunD     = underrunQ;
    stb.tick      = bitEn;
    stb.sel       = SEL_MARK;
    stb.flagBit   = 1'b0;
    stb.loadByte  = 1'b0;
    stb.presetFcs = 1'b0;

    if (!txEnable) begin
      if (bitEn) begin
        stateD    = ST_IDLE;
        cntD      = '0;
        eomD      = 1'b0;
        underrunD = 1'b0;
      end
    end else if (bitEn) begin
      unique case (stateQ)
        ST_IDLE: begin
          if (!gated) begin
            stateD = ST_FLAG;
            cntD   = '0;
          end
        end
        ST_FLAG: begin
          if (stuffDue) stb.sel = SEL_ZERO;
          else begin
            stb.sel     = SEL_FLAG;
            stb.flagBit = FLAG_OCTET[cntQ[2:0]];
            cntD        = cntQ + CNT_W'(1);
            if (cntQ == CNT_W'(7)) begin
              cntD = '0;
              if (gated) stateD = ST_IDLE;
              else if (bufFull) begin
                stateD        = ST_DATA;
                stb.loadByte  = 1'b1;
                stb.presetFcs = 1'b1;
                underrunD     = 1'b0;
                eomD          = 1'b0;
              end
            end
          end
        end
        ST_DATA: begin
          if (stuffDue) stb.sel = SEL_ZERO;
          else begin
            stb.sel = SEL_DATA;
            cntD    = cntQ + CNT_W'(1);
            if (cntQ == CNT_W'(BYTE_W - 1)) begin
              cntD = '0;
              if (eomQ || !bufFull) begin
                stateD    = ST_FCS;
                underrunD = !eomQ;
                eomD      = 1'b0;
              end else begin
                stb.loadByte = 1'b1;
              end
            end
          end
        end
        default: begin
          if (stuffDue) stb.sel = SEL_ZERO;
          else begin
            stb.sel = SEL_FCS;
            cntD    = cntQ + CNT_W'(1);
            if (cntQ == CNT_W'(FCS_W - 1)) begin
              cntD   = '0;
              stateD = ST_FLAG;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      cntQ      <= '0;
      eomQ      <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      cntQ      <= cntD;
      eomQ      <= eomD;
      underrunQ <= underrunD;
    end
  end

endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer
  import sdlc_tx_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          FCS_W     = 16,
  parameter logic [15:0] FCS_POLY  = 16'h8408,
  parameter int          RUN_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              ctsGateEn,
  input  logic              ctsActive,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] dataIn,
  output logic              dataReady,
  input  logic              eomReq,
  output logic              txd,
  output logic              bufEmpty,
  output logic              underrun
);

  txStrobe_t stb;
  logic      bufFull;
  logic      stuffDue;
  logic      txdReg;

  sdlc_tx_ctrl #(
    .BYTE_W(BYTE_W),
    .FCS_W (FCS_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .txEnable (txEnable),
    .ctsGateEn(ctsGateEn),
    .ctsActive(ctsActive),
    .eomReq   (eomReq),
    .bufFull  (bufFull),
    .stuffDue (stuffDue),
    .stb      (stb),
    .underrun (underrun)
  );

  sdlc_tx_dp #(
    .BYTE_W   (BYTE_W),
    .FCS_W    (FCS_W),
    .FCS_POLY (FCS_POLY),
    .RUN_LIMIT(RUN_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dataValid(dataValid),
    .dataIn   (dataIn),
    .dataReady(dataReady),
    .bufFull  (bufFull),
    .stuffDue (stuffDue),
    .txdReg   (txdReg)
  );

  assign txd      = sendBreak ? 1'b0 : txdReg;
  assign bufEmpty = ~bufFull;

endmodule

// File: rtl/sdlc_tx_framer_chk.sv
module sdlc_tx_framer_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic txEnable,
  input logic sendBreak,
  input logic dataValid,
  input logic dataReady,
  input logic bufEmpty,
  input logic underrun,
  input logic txd
);

  // R1: a tick taken while disabled leaves the line marking
  a_r1_mark_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!txEnable && bitEn) && !sendBreak) |-> txd);

  // R2: break holds the line low
  a_r2_break_low: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txd);

  // R4: an accepted byte fills the buffer
  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> !bufEmpty);

  // R8: underrun only arises from an empty buffer
  a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(bufEmpty));

  // R11: no tick, no line change
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(bitEn) && !sendBreak && !$past(sendBreak)) |-> $stable(txd));

endmodule

bind sdlc_tx_framer sdlc_tx_framer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bitEn    (bitEn),
  .txEnable (txEnable),
  .sendBreak(sendBreak),
  .dataValid(dataValid),
  .dataReady(dataReady),
  .bufEmpty (bufEmpty),
  .underrun (underrun),
  .txd      (txd)
);

// File: tb/test_sdlc_tx_framer.sv
module test_sdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b1;
  logic       txEnable = 1'b0;
  logic       sendBreak = 1'b0;
  logic       ctsGateEn = 1'b0;
  logic       ctsActive = 1'b1;
  logic       dataValid = 1'b0;
  logic [7:0] dataIn = '0;
  logic       dataReady;
  logic       eomReq = 1'b0;
  logic       txd;
  logic       bufEmpty;
  logic       underrun;

  int checks = 0;
  int failures = 0;

  sdlc_tx_framer i_sdlc_tx_framer (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .txEnable (txEnable),
    .sendBreak(sendBreak),
    .ctsGateEn(ctsGateEn),
    .ctsActive(ctsActive),
    .dataValid(dataValid),
    .dataIn   (dataIn),
    .dataReady(dataReady),
    .eomReq   (eomReq),
    .txd      (txd),
    .bufEmpty (bufEmpty),
    .underrun (underrun)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete");
    report();
  end

  // bit tick pattern
  bit bitMode = 1'b0;
  int cyc = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    bitEn = bitMode ? ((cyc % 3) != 0) : 1'b1;
  end

  logic bitSeen = 1'b1;
  always @(posedge clk) bitSeen <= bitEn;

  // receiving side: destuff and split frames at flags
  bit   rxOn = 1'b0;
  int   onesRun = 100;
  bit   rxBits [0:1023];
  int   rxLen = 0;
  int   stuffCnt = 0;
  logic [7:0] frameBytes [0:63];
  int   frameBits = 0;
  int   frameStuff = 0;
  int   frameCnt = 0;
  int   flagCnt = 0;
  int   stableErr = 0;
  logic lastTxd = 1'b1;

  always @(negedge clk) begin
    if (rxOn && !bitSeen && !sendBreak && txd !== lastTxd) stableErr++;
    lastTxd = txd;
    if (rxOn && bitSeen) begin
      if (txd) begin
        if (onesRun < 100) onesRun++;
      end else begin
        if (onesRun >= 7) begin
          rxLen = 0;
          stuffCnt = 0;
        end else if (onesRun == 6) begin
          if (rxLen <= 1) flagCnt++;
          else begin
            frameBits  = rxLen - 1;
            frameStuff = stuffCnt;
            for (int i = 0; i < frameBits / 8 && i < 64; i++)
              for (int j = 0; j < 8; j++) frameBytes[i][j] = rxBits[i*8+j];
            frameCnt++;
          end
          rxLen = 0;
          stuffCnt = 0;
        end else begin
          for (int k = 0; k < onesRun; k++) if (rxLen < 1024) begin
            rxBits[rxLen] = 1'b1;
            rxLen++;
          end
          if (onesRun == 5) stuffCnt++;
          else if (rxLen < 1024) begin
            rxBits[rxLen] = 1'b0;
            rxLen++;
          end
        end
        onesRun = 0;
      end
    end
  end

  // stimulus helpers
  logic [7:0] txBytes [0:15];

  function automatic logic [15:0] refFcs(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ txBytes[i][j]) c = (c >> 1) ^ 16'h8408;
        else c = c >> 1;
      end
    return ~c;
  endfunction

  function automatic int refStuff(input int n, input logic [15:0] f);
    int run = 0;
    int cnt = 0;
    bit b;
    for (int i = 0; i < n * 8 + 16; i++) begin
      b = (i < n * 8) ? txBytes[i/8][i%8] : f[i - n*8];
      run = b ? run + 1 : 0;
      if (run == 5) begin
        cnt++;
        run = 0;
      end
    end
    return cnt;
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!dataReady) @(negedge clk);
    dataValid = 1'b1;
    dataIn = b;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic pulseEom();
    while (!bufEmpty) @(negedge clk);
    eomReq = 1'b1;
    @(negedge clk);
    eomReq = 1'b0;
  endtask

  task automatic sendFrame(input int n, input bit withEom);
    for (int i = 0; i < n; i++) sendByte(txBytes[i]);
    if (withEom) pulseEom();
  endtask

  task automatic waitFrame(input int prev, input string req);
    int t = 0;
    while (frameCnt == prev && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(frameCnt != prev, req, "frame not seen", frameCnt, prev + 1);
  endtask

  task automatic checkFrame(input int n, input string req);
    logic [15:0] f;
    int bad = 0;
    f = refFcs(n);
    check(frameBits == (n + 2) * 8, req, "frame bit length", frameBits, (n + 2) * 8);
    for (int i = 0; i < n; i++) if (frameBytes[i] !== txBytes[i]) bad++;
    check(bad == 0, req, "payload bytes (R5)", frameBytes[0], txBytes[0]);
    check({frameBytes[n+1], frameBytes[n]} === f, "R7", "check sequence",
          {frameBytes[n+1], frameBytes[n]}, f);
    check(frameStuff == refStuff(n, f), "R6", "stuffed zero count",
          frameStuff, refStuff(n, f));
  endtask

  initial begin
    int f0;
    int bad;
    int prev;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(txd === 1'b1, "R1", "txd after reset", txd, 1);
    check(bufEmpty === 1'b1, "R1", "bufEmpty after reset", bufEmpty, 1);
    check(dataReady === 1'b1, "R1", "dataReady after reset", dataReady, 1);
    check(underrun === 1'b0, "R1", "underrun after reset", underrun, 0);

    // R2 break while disabled
    sendBreak = 1'b1;
    #1;
    check(txd === 1'b0, "R2", "txd during break", txd, 0);
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (txd !== 1'b0) bad++;
    end
    check(bad == 0, "R2", "break held low", bad, 0);
    sendBreak = 1'b0;
    #1;
    check(txd === 1'b1, "R2", "txd after break release", txd, 1);

    // R3 exact flag fill
    rxOn = 1'b1;
    @(negedge clk);
    txEnable = 1'b1;
    @(posedge clk);
    #1;
    check(txd === 1'b1, "R3", "first tick marks", txd, 1);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk);
      #1;
      if (txd !== sdlc_tx_pkg::FLAG_OCTET[i % 8]) bad++;
    end
    check(bad == 0, "R3", "back-to-back flag bits", bad, 0);
    check(bufEmpty === 1'b1, "R3", "buffer stays empty", bufEmpty, 1);

    // R10 eom during flag fill is ignored
    @(negedge clk);
    eomReq = 1'b1;
    @(negedge clk);
    eomReq = 1'b0;
    for (int i = 0; i < 3; i++) txBytes[i] = 8'(8'h31 + i * 8'h22);
    prev = frameCnt;
    sendFrame(3, 1'b1);
    waitFrame(prev, "R10");
    check(frameBits == 40, "R10", "frame length after stray eom", frameBits, 40);
    checkFrame(3, "R10");

    // R5 R6 R7 every single-byte payload
    for (int v = 0; v < 256; v++) begin
      txBytes[0] = 8'(v);
      prev = frameCnt;
      sendFrame(1, 1'b1);
      waitFrame(prev, "R5");
      checkFrame(1, "R5");
    end

    // R5 R6 multi-byte frames of assorted patterns
    for (int n = 2; n <= 6; n++) begin
      for (int k = 0; k < n; k++) txBytes[k] = 8'((k * 37 + n * 11) ^ 8'hA5);
      prev = frameCnt;
      sendFrame(n, 1'b1);
      waitFrame(prev, "R5");
      checkFrame(n, "R5");
    end
    for (int k = 0; k < 4; k++) txBytes[k] = 8'hFF;
    prev = frameCnt;
    sendFrame(4, 1'b1);
    waitFrame(prev, "R6");
    checkFrame(4, "R6");
    for (int k = 0; k < 3; k++) txBytes[k] = 8'h7E;
    prev = frameCnt;
    sendFrame(3, 1'b1);
    waitFrame(prev, "R6");
    checkFrame(3, "R6");

    // R8 underrun closes the frame
    txBytes[0] = 8'h5C;
    prev = frameCnt;
    sendFrame(1, 1'b0);
    waitFrame(prev, "R8");
    check(underrun === 1'b1, "R8", "underrun after dry buffer", underrun, 1);
    checkFrame(1, "R8");
    repeat (20) @(negedge clk);
    check(underrun === 1'b1, "R8", "underrun held between frames", underrun, 1);
    txBytes[0] = 8'h96;
    txBytes[1] = 8'h0F;
    prev = frameCnt;
    sendFrame(2, 1'b1);
    waitFrame(prev, "R8");
    check(underrun === 1'b0, "R8", "underrun cleared by new frame", underrun, 0);
    checkFrame(2, "R8");

    // R11 sparse ticks
    bitMode = 1'b1;
    stableErr = 0;
    for (int k = 0; k < 3; k++) txBytes[k] = 8'(8'hC3 - k * 8'h19);
    prev = frameCnt;
    sendFrame(3, 1'b1);
    waitFrame(prev, "R11");
    checkFrame(3, "R11");
    check(stableErr == 0, "R11", "txd moved without tick", stableErr, 0);
    bitMode = 1'b0;
    repeat (4) @(negedge clk);

    // R9 CTS gate: finish the current flag then mark
    ctsGateEn = 1'b1;
    repeat (13) @(negedge clk);
    f0 = flagCnt;
    ctsActive = 1'b0;
    repeat (10) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0, "R9", "line marks while gated", bad, 0);
    check(flagCnt == f0 + 1, "R9", "flags completed after gate", flagCnt - f0, 1);
    txBytes[0] = 8'hE7;
    sendByte(txBytes[0]);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0, "R9", "no frame start while gated", bad, 0);
    check(bufEmpty === 1'b0, "R4", "byte held in buffer", bufEmpty, 0);
    check(dataReady === 1'b0, "R4", "dataReady low when full", dataReady, 0);
    prev = frameCnt;
    ctsActive = 1'b1;
    pulseEom();
    waitFrame(prev, "R9");
    checkFrame(1, "R9");
    ctsGateEn = 1'b0;

    // R1 disable returns the line to marking
    @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0, "R1", "marking when disabled", bad, 0);

    report();
  end

endmodule